// File: doc/BRIEF.md
# Request/Wait Handshake Memory Master

This block lets a clocked processor reach a memory that has no clock of its own. The processor issues a read or a write with a single-cycle start pulse, along with an address, a direction and (for a write) a data word. The block then carries out a four-phase handshake toward the memory using two signals. It raises a request line. The memory holds a wait line high while idle and pulls it low to say that read data is valid or that write data has been taken. The block then drops the request and waits for the wait line to go high again.

The wait line comes from outside the clock domain, so it passes through a two-flop synchronizer before any edge is detected. One buffer register serves both directions. It holds the outgoing word during a write and catches the returning word during a read. When the handshake has fully closed, a one-cycle done pulse is raised. A start that arrives while a transfer is still open is dropped.

Top module: `rwm_master`

## Requirements
- R1: After reset, the request is low, busy is low, done is low, the buffer register reads 0 and the direction line is 1 (read).
- R2: A start pulse sampled while idle makes the request rise at the next clock edge. At that same edge busy rises, the address bus takes the start address and the direction line takes the start direction (1 = read, 0 = write).
- R3: While the request is high, the address bus and the direction line do not change.
- R4: During a write, the write-data bus carries the buffer register (which holds the start's write word) for every cycle the request is high. At all other times the write-data bus is 0.
- R5: The request falls on the third rising clock edge after the raw wait input falls, and it is still high after the second of those edges.
- R6: After a read, the buffer register holds the read-data input as it was when the request fell. After a write, it holds the written word.
- R7: Done is high for exactly one cycle. It rises on the third rising clock edge after the raw wait input returns high. Busy falls at that same edge.
- R8: A start pulse that arrives while busy is ignored. The address bus and the direction line keep their values, and no further request follows once the current transfer is done.
- R9: Busy stays high from the edge that accepts a start until the edge that raises done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle command start |
| rdNotWr | input | 1 | Command direction, 1 = read, 0 = write |
| cmdAddr | input | ADDR_W | Command address |
| cmdWrData | input | DATA_W | Command write word |
| memWaitRaw | input | 1 | Unsynchronized wait line from memory, high when idle |
| memRdData | input | DATA_W | Data returned by memory |
| memReq | output | 1 | Request toward memory |
| memRdWr | output | 1 | Direction toward memory, 1 = read |
| memAddr | output | ADDR_W | Address bus toward memory |
| memWrData | output | DATA_W | Write-data bus, buffer contents during a write request |
| readBuf | output | DATA_W | Buffer register contents |
| donePulse | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |

## Verification
Some properties are checked on every cycle: the address and direction stay stable under request, the write bus is gated, done is a single-cycle pulse that never coincides with request or busy, and a request rises only from an accepted start. The exact latency through the synchronizer, from a wait edge to the fall of request or the rise of done, needs a stimulated memory with a known edge time, so only the bench scenarios show it. The same holds for the captured read word and for the absence of a ghost transfer after an ignored start. The bench sweeps every address of a small configuration in both directions, with varied memory delays.

// File: rtl/rwm_pkg.sv
package rwm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_REL  = 2'd2
  } rwmState_e;

  typedef struct packed {
    logic loadCmd;    // latch address, direction and write word
    logic captureRd;  // latch memory data into the buffer on a read
    logic reqOn;      // request phase is open
  } rwmCtl_t;
endpackage

// File: rtl/rwm_datapath.sv
module rwm_datapath
  import rwm_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rwmCtl_t           ctl,
  input  logic              rdNotWr,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWrData,
  input  logic              memWaitRaw,
  input  logic [DATA_W-1:0] memRdData,
  output logic              waitFall,
  output logic              waitRise,
  output logic              memRdWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] readBuf
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] waitSync;
  logic                   waitPrev;
  logic [ADDR_W-1:0]      addrReg;
  logic                   rwReg;
  logic [DATA_W-1:0]      mbr;

  // Two-flop synchronizer plus one history flop, all idle-high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitSync <= '1;
      waitPrev <= 1'b1;
    end else begin
      waitSync <= {waitSync[SYNC_STAGES-2:0], memWaitRaw};
      waitPrev <= waitSync[SYNC_STAGES-1];
    end
  end

  assign waitFall = waitPrev & ~waitSync[SYNC_STAGES-1];
  assign waitRise = ~waitPrev & waitSync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      rwReg   <= 1'b1;
      mbr     <= '0;
    end else begin
      if (ctl.loadCmd) begin
        addrReg <= cmdAddr;
        rwReg   <= rdNotWr;
        if (!rdNotWr) mbr <= cmdWrData;
      end
      if (ctl.captureRd && rwReg) mbr <= memRdData;
    end
  end

  assign memAddr   = addrReg;
  assign memRdWr   = rwReg;
  assign memWrData = (ctl.reqOn && !rwReg) ? mbr : '0;
  assign readBuf   = mbr;
endmodule

// File: rtl/rwm_control.sv
module rwm_control
  import rwm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startPulse,
  input  logic    waitFall,
  input  logic    waitRise,
  output rwmCtl_t ctl,
  output logic    memReq,
  output logic    donePulse,
  output logic    busy
);
  rwmState_e state, stateNext;
  logic      doneReg;

  always_comb begin
    stateNext     = state;
    ctl           = '0;
    ctl.reqOn     = (state == ST_REQ);
    unique case (state)
      ST_IDLE: if (startPulse) begin
        ctl.loadCmd = 1'b1;
        stateNext   = ST_REQ;
      end
      ST_REQ: if (waitFall) begin
        ctl.captureRd = 1'b1;
        stateNext     = ST_REL;
      end
      ST_REL: if (waitRise) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneReg <= 1'b0;
    end else begin
      state   <= stateNext;
      doneReg <= (state == ST_REL) && waitRise;
    end
  end

  assign memReq    = (state == ST_REQ);
  assign busy      = (state != ST_IDLE);
  assign donePulse = doneReg;
endmodule

// File: rtl/rwm_master.sv
module rwm_master
  import rwm_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              rdNotWr,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWrData,
  input  logic              memWaitRaw,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memReq,
  output logic              memRdWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] readBuf,
  output logic              donePulse,
  output logic              busy
);
  rwmCtl_t ctl;
  logic    waitFall;
  logic    waitRise;

  rwm_control i_ctl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .waitFall(waitFall), .waitRise(waitRise), .ctl(ctl),
    .memReq(memReq), .donePulse(donePulse), .busy(busy)
  );

  rwm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdNotWr(rdNotWr),
    .cmdAddr(cmdAddr), .cmdWrData(cmdWrData), .memWaitRaw(memWaitRaw),
    .memRdData(memRdData), .waitFall(waitFall), .waitRise(waitRise),
    .memRdWr(memRdWr), .memAddr(memAddr), .memWrData(memWrData),
    .readBuf(readBuf)
  );
endmodule

// File: rtl/rwm_master_chk.sv
module rwm_master_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              rdNotWr,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic              memReq,
  input logic              memRdWr,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic [DATA_W-1:0] readBuf,
  input logic              donePulse,
  input logic              busy
);
  assert_req_from_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> ($past(startPulse) && !$past(busy) &&
                       memAddr == $past(cmdAddr) && memRdWr == $past(rdNotWr)));

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq)) |-> ($stable(memAddr) && $stable(memRdWr)));

  assert_wr_bus_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdWr) |-> (memWrData == readBuf));

  assert_wr_bus_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq || memRdWr) |-> (memWrData == '0));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busy && !memReq));

  assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && busy) |=> ($stable(memAddr) && $stable(memRdWr)));
endmodule

bind rwm_master rwm_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .rdNotWr(rdNotWr),
  .cmdAddr(cmdAddr), .memReq(memReq), .memRdWr(memRdWr), .memAddr(memAddr),
  .memWrData(memWrData), .readBuf(readBuf), .donePulse(donePulse), .busy(busy)
);

// File: tb/test_rwm_master.sv
module test_rwm_master;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic          rdNotWr = 1'b1;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdWrData = '0;
  logic          memWaitRaw = 1'b1;
  logic [DW-1:0] memRdData = '0;
  logic          memReq, memRdWr, donePulse, busy;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWrData, readBuf;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rwm_master #(.ADDR_W(AW), .DATA_W(DW)) i_rwm_master (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .rdNotWr(rdNotWr),
    .cmdAddr(cmdAddr), .cmdWrData(cmdWrData), .memWaitRaw(memWaitRaw),
    .memRdData(memRdData), .memReq(memReq), .memRdWr(memRdWr),
    .memAddr(memAddr), .memWrData(memWrData), .readBuf(readBuf),
    .donePulse(donePulse), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  task automatic doTxn(input logic rd, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input logic [DW-1:0] rdv, input int d1, input int d2, input logic poke);
    logic [DW-1:0] expBuf;
    expBuf = rd ? rdv : wd;
    @(negedge clk);
    startPulse = 1'b1; rdNotWr = rd; cmdAddr = a; cmdWrData = wd;
    @(negedge clk);
    startPulse = 1'b0; cmdAddr = ~a; rdNotWr = ~rd; cmdWrData = ~wd;
    chk("R2 req", memReq, 1'b1);
    chk("R9 busy", busy, 1'b1);
    chk("R2 addr", memAddr, a);
    chk("R2 dir", memRdWr, rd);
    if (poke) begin
      startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
      chk("R8 addr kept", memAddr, a);
      chk("R8 dir kept", memRdWr, rd);
    end
    for (int i = 0; i < d1; i++) begin
      @(negedge clk);
      chk("R3 addr", memAddr, a);
      chk("R4 wbus", memWrData, rd ? '0 : wd);
    end
    memRdData = rdv;
    memWaitRaw = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R5 still req", memReq, 1'b1);
    @(posedge clk); #1;
    chk("R5 req fell", memReq, 1'b0);
    chk("R6 buffer", readBuf, expBuf);
    chk("R4 wbus idle", memWrData, '0);
    memRdData = ~rdv;
    for (int i = 0; i < d2; i++) begin
      @(negedge clk);
      chk("R9 busy hold", busy, 1'b1);
      chk("R7 no early done", donePulse, 1'b0);
    end
    @(negedge clk);
    memWaitRaw = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R7 not yet", donePulse, 1'b0);
    @(posedge clk); #1;
    chk("R7 done", donePulse, 1'b1);
    chk("R7 busy fell", busy, 1'b0);
    @(posedge clk); #1;
    chk("R7 single", donePulse, 1'b0);
    chk("R6 buffer kept", readBuf, expBuf);
    if (poke) begin
      @(posedge clk); #1;
      chk("R8 no ghost req", memReq, 1'b0);
      chk("R8 no ghost busy", busy, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 req", memReq, 1'b0);
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", donePulse, 1'b0);
    chk("R1 buf", readBuf, '0);
    chk("R1 dir", memRdWr, 1'b1);
    chk("R1 wbus", memWrData, '0);
    for (int a = 0; a < (1 << AW); a++) begin
      for (int r = 0; r < 2; r++) begin
        doTxn(r[0], a[AW-1:0], DW'(a * 17 + 3), DW'(a * 29 + 5 + r * 64),
              (a + r) % 4, (a * 3) % 5, a[0]);
      end
    end
    finishRun();
  end
endmodule